// File: doc/BRIEF.md
# Threshold-Gated Multi-Context Pass Switch

This block is a cycle-level digital model of one routing pass switch whose on/off state is reconfigured for each context. The switch does not store one bit per context and pick among them with a multiplexer. It turns the context index into a multi-level value and its mirror image. Each of these is masked by the low index bit, and by the bank-select bits when there are more than four contexts. For each group of four contexts there are two threshold elements. Each element compares one masked level against a programmed threshold. The pass output is the OR of all elements.

Software-visible behaviour is simple. A configuration word with one bit per context is loaded. After that, the data input reaches the output only while the current context's bit is set. Internally, each 4-bit group is compiled into a selector and a doubled-integer threshold for each of its two elements.

The threshold arithmetic works on small integers:

- The base level is 2·b1 + b0 + 1, where b1 and b0 are the two low index bits.
- The mirror level is 5 minus the base level.
- A threshold is stored at twice its value, so half-steps can be represented. The stored value 10 means "never conducts".
- An element conducts when twice its selected level is at least its stored threshold.

Top module: `hsw_switch`

## Requirements
- R1: While reset is high and after reset, the stored configuration is all zero, so `pass_en` is 0, `elem_on` is 0 and `dout` is 0 for every context.
- R2: Configuration bit k enables context k. For every 4-bit group pattern (all 16) and every context of the group, `pass_en` equals the stored bit of the current context `ctx_idx`.
- R3: Element `elem_on[2q]` conducts only when `ctx_idx[0]` is 0. Element `elem_on[2q+1]` conducts only when `ctx_idx[0]` is 1.
- R4: At most one bit of `elem_on` is set at any time.
- R5: `dout` equals `din` when `pass_en` is 1, and equals 0 otherwise.
- R6: Raising `cfg_load` captures `cfg_bits` at the next rising clock edge. Until that edge, the earlier configuration still decides `pass_en`.
- R7: A change of `ctx_idx` changes `pass_en` and `dout` within the same cycle, with no clock edge needed.
- R8: While `cfg_load` is 0, changes on `cfg_bits` have no effect on `pass_en` for any context.
- R9: With more than four contexts, bits `ctx_idx[IDX_W-1:2]` select group q, and only the pair `elem_on[2q+1:2q]` of that group can conduct.
- R10: The configuration with bits 0..3 of a group equal to 0,1,0,1 passes data in that group's contexts 1 and 3 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctx_idx | input | IDX_W | Current context index |
| cfg_load | input | 1 | Capture `cfg_bits` at the next edge |
| cfg_bits | input | NUM_CTX | One enable bit per context |
| din | input | DATA_W | Data entering the switch |
| dout | output | DATA_W | Data leaving the switch, zero when off |
| pass_en | output | 1 | Switch conducts in the current context |
| elem_on | output | 2*NUM_CTX/4 | Per-element conduct flags, even-parity element of group q at bit 2q |

## Verification
Suppose a group's compiled selector or threshold is wrong. Then `pass_en` differs from the configured bit for some context, and the difference shows in the same cycle that context is presented. A full sweep of patterns and contexts therefore exposes it on the first affected combination. A masking fault in the level generator shows up in `elem_on` instead. The fault lights a wrong element or two elements at once, again combinationally. A fault in the load path shows up exactly one edge after `cfg_load`, or as a change while `cfg_load` is low.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef logic [2:0] lvl_t;
    typedef logic [3:0] thr_t;

    typedef enum logic {
        SEL_BASE   = 1'b0,
        SEL_MIRROR = 1'b1
    } sel_e;

    typedef struct packed {
        sel_e sel;
        thr_t thr;
    } elem_cfg_t;

    typedef struct packed {
        lvl_t odd_base;
        lvl_t odd_mirror;
        lvl_t even_base;
        lvl_t even_mirror;
    } hyb_t;

    localparam thr_t THR_NEVER = 4'd10;
    localparam thr_t THR_ANY   = 4'd1;

    function automatic lvl_t base_level(logic [1:0] low_bits);
        return lvl_t'(low_bits) + lvl_t'(1);
    endfunction

    function automatic lvl_t mirror_level(lvl_t v);
        return lvl_t'(5) - v;
    endfunction

    function automatic elem_cfg_t compile_pair(logic lo_on, logic hi_on, logic odd);
        lvl_t lo_v;
        lvl_t hi_v;
        elem_cfg_t r;
        lo_v = base_level({1'b0, odd});
        hi_v = base_level({1'b1, odd});
        case ({hi_on, lo_on})
            2'b10:   r = '{sel: SEL_BASE,   thr: thr_t'(lo_v) + thr_t'(hi_v)};
            2'b01:   r = '{sel: SEL_MIRROR, thr: thr_t'(mirror_level(lo_v)) + thr_t'(mirror_level(hi_v))};
            2'b11:   r = '{sel: SEL_BASE,   thr: THR_ANY};
            default: r = '{sel: SEL_BASE,   thr: THR_NEVER};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hsw_level_gen.sv
module hsw_level_gen
    import hsw_pkg::*;
#(
    parameter int NUM_CTX = 8,
    localparam int IDX_W  = $clog2(NUM_CTX),
    localparam int NQ     = NUM_CTX / 4
) (
    input  logic [IDX_W-1:0]    ctx_idx,
    output hyb_t [NQ-1:0]       hyb
);
    lvl_t base_v;
    lvl_t mirror_v;

    always_comb begin
        base_v   = base_level(ctx_idx[1:0]);
        mirror_v = mirror_level(base_v);
    end

    for (genvar q = 0; q < NQ; q++) begin : g_grp
        logic grp_sel;
        if (NQ == 1) begin : g_one
            assign grp_sel = 1'b1;
        end else begin : g_many
            assign grp_sel = (ctx_idx[IDX_W-1:2] == (IDX_W-2)'(q));
        end
        logic odd_gate;
        logic even_gate;
        assign odd_gate  = grp_sel &  ctx_idx[0];
        assign even_gate = grp_sel & ~ctx_idx[0];
        assign hyb[q].odd_base    = odd_gate  ? base_v   : '0;
        assign hyb[q].odd_mirror  = odd_gate  ? mirror_v : '0;
        assign hyb[q].even_base   = even_gate ? base_v   : '0;
        assign hyb[q].even_mirror = even_gate ? mirror_v : '0;
    end
endmodule

// File: rtl/hsw_cfg_bank.sv
module hsw_cfg_bank
    import hsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [3:0] bits_in,
    output elem_cfg_t  even_cfg,
    output elem_cfg_t  odd_cfg
);
    logic [3:0] stored;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored <= '0;
        end else if (load) begin
            stored <= bits_in;
        end
    end

    always_comb begin
        even_cfg = compile_pair(stored[0], stored[2], 1'b0);
        odd_cfg  = compile_pair(stored[1], stored[3], 1'b1);
    end
endmodule

// File: rtl/hsw_thr_elem.sv
module hsw_thr_elem
    import hsw_pkg::*;
(
    input  lvl_t      lvl_base,
    input  lvl_t      lvl_mirror,
    input  elem_cfg_t cfg,
    output logic      on
);
    lvl_t gate_lvl;

    always_comb begin
        gate_lvl = (cfg.sel == SEL_MIRROR) ? lvl_mirror : lvl_base;
        on       = ({gate_lvl, 1'b0} >= cfg.thr);
    end
endmodule

// File: rtl/hsw_switch.sv
module hsw_switch
    import hsw_pkg::*;
#(
    parameter int NUM_CTX = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_CTX),
    localparam int NQ     = NUM_CTX / 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    ctx_idx,
    input  logic                cfg_load,
    input  logic [NUM_CTX-1:0]  cfg_bits,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout,
    output logic                pass_en,
    output logic [2*NQ-1:0]     elem_on
);
    hyb_t [NQ-1:0] hyb;

    hsw_level_gen #(.NUM_CTX(NUM_CTX)) u_lvl (
        .ctx_idx (ctx_idx),
        .hyb     (hyb)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_grp
        elem_cfg_t even_cfg;
        elem_cfg_t odd_cfg;

        hsw_cfg_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .load     (cfg_load),
            .bits_in  (cfg_bits[4*q +: 4]),
            .even_cfg (even_cfg),
            .odd_cfg  (odd_cfg)
        );

        hsw_thr_elem u_even (
            .lvl_base   (hyb[q].even_base),
            .lvl_mirror (hyb[q].even_mirror),
            .cfg        (even_cfg),
            .on         (elem_on[2*q])
        );

        hsw_thr_elem u_odd (
            .lvl_base   (hyb[q].odd_base),
            .lvl_mirror (hyb[q].odd_mirror),
            .cfg        (odd_cfg),
            .on         (elem_on[2*q+1])
        );
    end

    always_comb begin
        pass_en = |elem_on;
        dout    = pass_en ? din : '0;
    end
endmodule

// File: rtl/hsw_switch_chk.sv
module hsw_switch_chk #(
    parameter int NUM_CTX = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_CTX),
    localparam int NQ     = NUM_CTX / 4
) (
    input logic                clk,
    input logic                rst,
    input logic [IDX_W-1:0]    ctx_idx,
    input logic                cfg_load,
    input logic [NUM_CTX-1:0]  cfg_bits,
    input logic [DATA_W-1:0]   din,
    input logic [DATA_W-1:0]   dout,
    input logic                pass_en,
    input logic [2*NQ-1:0]     elem_on
);
    logic               load_d;
    logic [NUM_CTX-1:0] bits_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_d <= 1'b0;
            bits_d <= '0;
        end else begin
            load_d <= cfg_load;
            bits_d <= cfg_bits;
        end
    end

    // R4: elements are mutually exclusive
    p_excl_r4: assert property (@(posedge clk) disable iff (rst) $onehot0(elem_on));

    // R5: output follows input only when enabled
    p_dout_r5: assert property (@(posedge clk) disable iff (rst)
        (pass_en ? (dout == din) : (dout == '0)));

    // R3: element parity matches index parity
    for (genvar q = 0; q < NQ; q++) begin : g_par
        p_parity_r3: assert property (@(posedge clk) disable iff (rst)
            (elem_on[2*q] |-> !ctx_idx[0]) and (elem_on[2*q+1] |-> ctx_idx[0]));
    end

    // R6: captured configuration decides the cycle after a load
    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        load_d |-> (pass_en == bits_d[ctx_idx]));

    // R8: without a load and with a fixed context, enable holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!load_d && $stable(ctx_idx)) |-> $stable(pass_en));
endmodule

bind hsw_switch hsw_switch_chk #(.NUM_CTX(NUM_CTX), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_hsw_switch.sv
module tb_hsw_switch;
    localparam int NUM_CTX = 8;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = $clog2(NUM_CTX);
    localparam int NQ      = NUM_CTX / 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [IDX_W-1:0]    ctx_idx = '0;
    logic                cfg_load = 1'b0;
    logic [NUM_CTX-1:0]  cfg_bits = '0;
    logic [DATA_W-1:0]   din = '0;
    logic [DATA_W-1:0]   dout;
    logic                pass_en;
    logic [2*NQ-1:0]     elem_on;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    hsw_switch #(.NUM_CTX(NUM_CTX), .DATA_W(DATA_W)) dut (.*);

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (ctx %0d)", req, act, exp, ctx_idx);
        end
    endtask

    task automatic load_cfg(logic [NUM_CTX-1:0] b);
        @(negedge clk);
        cfg_bits = b;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // expected outputs for configuration cfg and context c
    task automatic check_ctx(string req, logic [NUM_CTX-1:0] cfg, int c, logic [DATA_W-1:0] d);
        logic [2*NQ-1:0] exp_on;
        ctx_idx = IDX_W'(c);
        din     = d;
        #1;
        exp_on = '0;
        if (cfg[c]) exp_on[2*(c/4) + (c%2)] = 1'b1;
        check(req, int'(pass_en), int'(cfg[c]));
        check(req, int'(elem_on), int'(exp_on));
        check(req, int'(dout), cfg[c] ? int'(d) : 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        for (int c = 0; c < NUM_CTX; c++) check_ctx("R1 in reset", '0, c, 8'hA5);
        rst = 1'b0;
        @(negedge clk);
        for (int c = 0; c < NUM_CTX; c++) check_ctx("R1 after reset", '0, c, 8'h5A);
    endtask

    // R2 R3 R4 R5 R9: every pair of group patterns, every context
    task automatic t_sweep();
        for (int p = 0; p < 256; p++) begin
            load_cfg(NUM_CTX'(p));
            for (int c = 0; c < NUM_CTX; c++)
                check_ctx("R2/R3/R9 sweep", NUM_CTX'(p), c, DATA_W'(p * 7 + c + 1));
        end
    endtask

    task automatic t_example();
        load_cfg(8'b1010_1010);
        for (int c = 0; c < NUM_CTX; c++) check_ctx("R10 pattern 0101", 8'b1010_1010, c, 8'hC3);
    endtask

    task automatic t_load_timing();
        load_cfg(8'h0F);
        @(negedge clk);
        ctx_idx  = 3'd5;
        cfg_bits = 8'hF0;
        cfg_load = 1'b1;
        #1;
        check("R6 before edge", int'(pass_en), 0);
        @(posedge clk);
        #1;
        check("R6 after edge", int'(pass_en), 1);
        @(negedge clk);
        cfg_load = 1'b0;
        ctx_idx  = 3'd2;
        #1;
        check("R6 old bits gone", int'(pass_en), 0);
    endtask

    task automatic t_ignore();
        load_cfg(8'h3C);
        @(negedge clk);
        cfg_bits = 8'hC3;
        repeat (2) @(negedge clk);
        for (int c = 0; c < NUM_CTX; c++) check_ctx("R8 no load", 8'h3C, c, 8'h11);
    endtask

    task automatic t_ctx_comb();
        load_cfg(8'h81);
        @(negedge clk);
        @(posedge clk);
        #2;
        ctx_idx = 3'd7;
        din     = 8'h77;
        #1;
        check("R7 mid-cycle enable", int'(pass_en), 1);
        check("R7 mid-cycle data", int'(dout), 8'h77);
        ctx_idx = 3'd6;
        #1;
        check("R7 mid-cycle off", int'(pass_en), 0);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_example();
        t_load_timing();
        t_ignore();
        t_ctx_comb();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule